// File: doc/BRIEF.md
# Serial SAR ADC Conversion Sequencer

This block sits in an FPGA and runs an external 18-bit successive-approximation converter with a serial data output. A one-cycle `start` request makes it raise the convert strobe. It holds the strobe high for the worst-case conversion time, then drops it so that the converter drives its MSB. It then produces 18 serial clock pulses and captures one bit on each rising edge. The finished word appears on a parallel output together with a one-cycle valid pulse. The next conversion may begin only after the minimum cycle time, which is measured from the previous strobe rise.

All timing is counted in system-clock cycles and set by parameters. Immediate assertions run at elaboration and check each count against the nanosecond minimums for the configured clock period. A start request that arrives while a cycle is running is remembered and served as soon as the cycle timer allows it.

The state machine has five states. `ST_IDLE` goes to `ST_CONVERT` on a request. `ST_CONVERT` goes to `ST_SHIFT` when the conversion count expires. `ST_SHIFT` goes to `ST_DELIVER` after the final falling serial clock edge. `ST_DELIVER` always goes to `ST_RECOVER`. `ST_RECOVER` waits for the cycle window to close, then goes to `ST_CONVERT` if a request is pending, or to `ST_IDLE` if none is.

Top module: `sar_readout_ctrl`

## Requirements
- R1: When a start request is sampled in idle, `adc_cnv` and `busy` are both high from the next clock edge.
- R2: `adc_cnv` stays high for exactly CONV_CYC clock cycles per conversion, and `adc_sck` is low the whole time `adc_cnv` is high.
- R3: After `adc_cnv` falls, exactly 18 serial clock pulses follow. Each low phase, including the first one after the strobe falls, and each high phase lasts SCK_HALF clock cycles. `adc_sck` then stays low.
- R4: `adc_sdo` is sampled at each rising `adc_sck`. The first bit becomes `data_out[17]` and the last becomes `data_out[0]`, so the two's-complement code passes through unchanged (0x20000 is negative full scale, 0x1FFFF is positive full scale).
- R5: `data_valid` is high for exactly one cycle, in the same cycle that `busy` falls. `data_out` holds its value until the next valid pulse.
- R6: Two consecutive rising edges of `adc_cnv` are never less than CYCLE_CYC clock cycles apart.
- R7: A start request that arrives during a running cycle is kept pending. `adc_cnv` then rises exactly CYCLE_CYC cycles after the previous rise, and several requests during one cycle lead to only one extra conversion.
- R8: Elaboration checks that CONV_CYC covers 500 ns, CYCLE_CYC covers 750 ns, SCK_HALF covers 14 ns of data-valid delay, and the serial clock period covers 10.5 ns.
- R9: While reset is held, `adc_cnv`, `adc_sck`, `busy`, `data_valid` and `data_out` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Conversion request, one cycle wide |
| adc_sdo | input | 1 | Serial data from the converter |
| adc_cnv | output | 1 | Convert strobe; high while sampling and converting |
| adc_sck | output | 1 | Serial clock to the converter, idle low |
| data_out | output | 18 | Last captured two's-complement code |
| data_valid | output | 1 | One-cycle pulse when data_out updates |
| busy | output | 1 | High from strobe rise until the valid pulse |

## Verification
The bench builds the block with CONV_CYC = 25, SCK_HALF = 1 and CYCLE_CYC = 80 on a 20 ns clock. Because 80 cycles is longer than the 62 cycles a full conversion and readout need, the state machine actually waits in the recovery state. A request made during a cycle therefore has to be held, and the exact spacing of the strobe edges can be measured. The single-cycle serial clock half period tests the tightest case of the phase counter, where each rising edge has to follow the preceding edge after only one cycle.

// File: rtl/sar_readout_pkg.sv
package sar_readout_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CONVERT,
        ST_SHIFT,
        ST_DELIVER,
        ST_RECOVER
    } sar_state_e;

    // Device minimums in picoseconds
    localparam longint T_CONV_MAX_PS   = 500_000;
    localparam longint T_CYCLE_MIN_PS  = 750_000;
    localparam longint T_SDO_VALID_PS  = 14_000;
    localparam longint T_SCK_PER_PS    = 10_500;

endpackage

// File: rtl/sar_cycle_timer.sv
module sar_cycle_timer #(
    parameter int LIMIT = 38
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic window_ok
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LIM = CW'(LIMIT);

    logic [CW-1:0] elapsed;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            elapsed <= LIM;
        else if (restart)
            elapsed <= CW'(1);
        else if (elapsed < LIM)
            elapsed <= elapsed + CW'(1);
    end

    assign window_ok = (elapsed >= LIM);

    // A new strobe may only start once the previous window has closed
    assert_restart_in_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
        restart |-> window_ok);

endmodule

// File: rtl/sar_sck_shifter.sv
module sar_sck_shifter #(
    parameter int HALF = 1,
    parameter int BITS = 18
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic            sdo,
    output logic            sck,
    output logic [BITS-1:0] word,
    output logic            last
);
    localparam int PW = (HALF > 1) ? $clog2(HALF) : 1;
    localparam int NW = $clog2(BITS + 1);
    localparam logic [PW-1:0] PH_END = PW'(HALF - 1);
    localparam logic [NW-1:0] N_END  = NW'(BITS);

    logic [PW-1:0] phase;
    logic [NW-1:0] nbits;
    logic          sck_q;
    logic          edge_now;

    assign edge_now = en && (phase == PH_END);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase <= '0;
            nbits <= '0;
            sck_q <= 1'b0;
            word  <= '0;
        end else if (!en) begin
            phase <= '0;
            nbits <= '0;
            sck_q <= 1'b0;
        end else if (edge_now) begin
            phase <= '0;
            sck_q <= ~sck_q;
            if (!sck_q) begin
                word  <= {word[BITS-2:0], sdo};
                nbits <= nbits + NW'(1);
            end
        end else begin
            phase <= phase + PW'(1);
        end
    end

    assign sck  = sck_q;
    assign last = edge_now && sck_q && (nbits == N_END);

    assert_bit_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
        nbits <= N_END);
    assert_sck_idle_after_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(en) |-> !sck_q);

endmodule

// File: rtl/sar_readout_ctrl.sv
module sar_readout_ctrl
    import sar_readout_pkg::*;
#(
    parameter int CLK_PERIOD_PS = 20_000,
    parameter int CONV_CYC      = 25,
    parameter int SCK_HALF      = 1,
    parameter int CYCLE_CYC     = 38,
    parameter int DATA_BITS     = 18
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic                 adc_sdo,
    output logic                 adc_cnv,
    output logic                 adc_sck,
    output logic [DATA_BITS-1:0] data_out,
    output logic                 data_valid,
    output logic                 busy
);
    localparam int CW = $clog2(CONV_CYC + 1);
    localparam logic [CW-1:0] CONV_LAST = CW'(CONV_CYC - 1);

    sar_state_e state, nxt;
    logic [CW-1:0] conv_cnt;
    logic pend, req, window_ok, restart, shift_last;
    logic [DATA_BITS-1:0] shift_word;

    initial begin
        assert_conv_time_R8: assert (longint'(CONV_CYC) * longint'(CLK_PERIOD_PS) >= T_CONV_MAX_PS)
            else $error("R8: CONV_CYC too short");
        assert_cycle_time_R8: assert (longint'(CYCLE_CYC) * longint'(CLK_PERIOD_PS) >= T_CYCLE_MIN_PS)
            else $error("R8: CYCLE_CYC too short");
        assert_sdo_setup_R8: assert (longint'(SCK_HALF) * longint'(CLK_PERIOD_PS) >= T_SDO_VALID_PS)
            else $error("R8: SCK_HALF too short for data-valid delay");
        assert_sck_period_R8: assert (longint'(2 * SCK_HALF) * longint'(CLK_PERIOD_PS) >= T_SCK_PER_PS)
            else $error("R8: serial clock period too short");
    end

    assign req = start || pend;

    // Next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:    if (req && window_ok)         nxt = ST_CONVERT;
            ST_CONVERT: if (conv_cnt == CONV_LAST)    nxt = ST_SHIFT;
            ST_SHIFT:   if (shift_last)               nxt = ST_DELIVER;
            ST_DELIVER:                               nxt = ST_RECOVER;
            ST_RECOVER: if (window_ok)                nxt = req ? ST_CONVERT : ST_IDLE;
            default:                                  nxt = ST_IDLE;
        endcase
    end

    assign restart = (nxt == ST_CONVERT) && (state != ST_CONVERT);

    // State register and its counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            conv_cnt <= '0;
            pend     <= 1'b0;
            data_out <= '0;
        end else begin
            state    <= nxt;
            conv_cnt <= (state == ST_CONVERT) ? conv_cnt + CW'(1) : '0;
            pend     <= restart ? 1'b0 : (pend || start);
            if (shift_last)
                data_out <= shift_word;
        end
    end

    // Outputs
    always_comb begin
        adc_cnv    = 1'b0;
        busy       = 1'b0;
        data_valid = 1'b0;
        unique case (state)
            ST_CONVERT: begin adc_cnv = 1'b1; busy = 1'b1; end
            ST_SHIFT:   busy = 1'b1;
            ST_DELIVER: data_valid = 1'b1;
            default:    ;
        endcase
    end

    sar_cycle_timer #(.LIMIT(CYCLE_CYC)) u_cycle (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (restart),
        .window_ok (window_ok)
    );

    sar_sck_shifter #(.HALF(SCK_HALF), .BITS(DATA_BITS)) u_shift (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (state == ST_SHIFT),
        .sdo   (adc_sdo),
        .sck   (adc_sck),
        .word  (shift_word),
        .last  (shift_last)
    );

    assert_sck_low_in_conv_R2: assert property (@(posedge clk) disable iff (!rst_n)
        adc_cnv |-> !adc_sck);
    assert_conv_length_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(adc_cnv) |-> $past(conv_cnt) == CONV_LAST);
    assert_valid_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        data_valid |=> !data_valid);
    assert_busy_ends_at_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> data_valid);
    assert_pending_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (start && busy) |=> pend);

endmodule

// File: tb/sar_readout_ctrl_test.sv
`timescale 1ns/1ps
module sar_readout_ctrl_test;
    localparam int CONV = 25;
    localparam int HALF = 1;
    localparam int CYC  = 80;
    localparam int W    = 18;
    localparam int TCK  = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic sdo = 1'b0;
    logic cnv, sck, valid, busy;
    logic [W-1:0] dout;

    always #10 clk = ~clk;

    sar_readout_ctrl #(.CLK_PERIOD_PS(20_000), .CONV_CYC(CONV), .SCK_HALF(HALF),
                       .CYCLE_CYC(CYC), .DATA_BITS(W)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .adc_sdo(sdo),
        .adc_cnv(cnv), .adc_sck(sck), .data_out(dout),
        .data_valid(valid), .busy(busy));

    int n_chk = 0, n_fail = 0, n_valid = 0, cnv_rises = 0, sck_pulses = 0;
    logic [W-1:0] exp_q[$];
    logic [W-1:0] mdl_q[$];
    logic [W-1:0] mword = '0;
    int  midx = 0;
    bit  loaded = 1'b1;
    bit  prev_valid = 1'b0;
    time t_rise = 0, t_prev_rise = 0, t_sck_rise = 0, t_sck_fall = 0;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Behavioural converter: word latched at strobe rise, MSB on strobe fall, next bit on each falling SCK
    always @(posedge cnv) begin
        mword  = (mdl_q.size() > 0) ? mdl_q.pop_front() : '0;
        loaded = 1'b0;
    end
    always @(negedge cnv or negedge sck) begin
        if (!loaded) begin
            midx = W - 1;
            loaded = 1'b1;
        end else if (midx > 0) begin
            midx--;
        end
        sdo = mword[midx];
    end

    // Timing monitors
    always @(posedge cnv) begin
        if (cnv_rises > 0)
            check(($time - t_rise) >= CYC * TCK, "R6 strobe spacing", 32'($time - t_rise), 32'(CYC * TCK));
        check(!sck, "R2 sck low at strobe rise", 32'(sck), 0);
        t_prev_rise = t_rise;
        t_rise = $time;
        cnv_rises++;
    end
    always @(negedge cnv) if (cnv_rises > 0) begin
        check(($time - t_rise) == CONV * TCK, "R2 strobe width", 32'($time - t_rise), 32'(CONV * TCK));
        sck_pulses = 0;
        t_sck_fall = $time;
    end
    always @(posedge sck) begin
        check(($time - t_sck_fall) == HALF * TCK, "R3 sck low phase", 32'($time - t_sck_fall), 32'(HALF * TCK));
        check(!cnv, "R2 sck while strobe high", 32'(cnv), 0);
        t_sck_rise = $time;
        sck_pulses++;
    end
    always @(negedge sck) if (cnv_rises > 0) begin
        check(($time - t_sck_rise) == HALF * TCK, "R3 sck high phase", 32'($time - t_sck_rise), 32'(HALF * TCK));
        t_sck_fall = $time;
    end

    // Scoreboard monitor
    always @(negedge clk) if (rst_n) begin
        if (prev_valid)
            check(!valid, "R5 valid width", 32'(valid), 0);
        if (valid) begin
            n_valid++;
            if (exp_q.size() == 0) begin
                check(1'b0, "R4 unexpected word", 32'(dout), 0);
            end else begin
                logic [W-1:0] e;
                e = exp_q.pop_front();
                check(dout == e, "R4 captured word", 32'(dout), 32'(e));
            end
            check(sck_pulses == W, "R3 pulse count", 32'(sck_pulses), 32'(W));
            check(!sck, "R3 sck idle low", 32'(sck), 0);
            check(!busy, "R5 busy low with valid", 32'(busy), 0);
        end
        prev_valid = valid;
    end

    task automatic push(input logic [W-1:0] w);
        exp_q.push_back(w);
        mdl_q.push_back(w);
    endtask

    task automatic pulse_idle();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        check(cnv && busy, "R1 strobe and busy after start", {30'd0, cnv, busy}, 32'h3);
    endtask

    task automatic pulse_busy();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    task automatic wait_valids(input int target);
        while (n_valid < target) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (200_000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R1 watchdog actual=timeout expected=completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : main
        logic [W-1:0] words [6];
        int base;
        words = '{18'h20000, 18'h1FFFF, 18'h00000, 18'h3FFFF, 18'h2AAAA, 18'h15555};
        repeat (5) @(negedge clk);
        check({cnv, sck, busy, valid} == 4'b0, "R9 control outputs in reset", {28'd0, cnv, sck, busy, valid}, 0);
        check(dout == '0, "R9 data in reset", 32'(dout), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        for (int i = 0; i < 6; i++) begin
            push(words[i]);
            pulse_idle();
            wait_valids(i + 1);
            repeat (40) @(negedge clk);
            check(dout == words[i], "R5 data held after valid", 32'(dout), 32'(words[i]));
            check(!cnv && !busy, "R7 no stray conversion", {30'd0, cnv, busy}, 0);
        end
        check(cnv_rises == 6, "R1 one strobe per request", 32'(cnv_rises), 6);

        // Requests during a running cycle: several collapse into one pending conversion
        base = cnv_rises;
        push(18'h0ABCD);
        push(18'h3C3C3);
        pulse_idle();
        repeat (10) @(negedge clk);
        pulse_busy();
        repeat (20) @(negedge clk);
        pulse_busy();
        repeat (35) @(negedge clk);
        pulse_busy();
        wait_valids(8);
        check((t_rise - t_prev_rise) == CYC * TCK, "R7 pending start spacing",
              32'(t_rise - t_prev_rise), 32'(CYC * TCK));
        repeat (200) @(negedge clk);
        check(cnv_rises - base == 2, "R7 pending requests collapse", 32'(cnv_rises - base), 2);
        check(dout == 18'h3C3C3, "R5 data held after pending run", 32'(dout), 32'h3C3C3);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule